// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block is the external memory port of a small 8-bit controller core. The core asks for one read or one write at a time, with a 16-bit address, a data-memory select flag and, for writes, a data byte. The controller then runs one bus machine cycle. It places the low address byte on a shared byte-wide lane, places the high address byte on a dedicated lane, and times both with an active-low address strobe. It then uses the same shared lane for data, timed by an active-low data strobe.

The shared lane is split into an output byte, an output enable and an input byte, so the pad ring can build the tri-state driver. A read releases the lane before the data strobe falls. The byte on the lane is taken in the last clock that the data strobe is low. The core sees completion as a one-clock acknowledge, and read data is valid on that same clock.

A write-only configuration byte holds a timing-select bit. When that bit is set, the controller inserts one extra timing state, which keeps the data strobe low for longer so that slow memories can respond. The register comes out of reset with the longer timing selected. A new setting is sampled only when a transaction is accepted.

Top module: `mux_bus_ctrl`

## Requirements
- R1: While reset is applied and after it is released, with no request pending: both strobes are high (1), the lane output enable is 0, the acknowledge is 0, read data is 0, and the read/write line is high (read).
- R2: Each transaction starts one clock after the request is seen. The address strobe is low for exactly that first clock. When the address strobe rises, the lane output enable is 1 and the lane carries the low address byte. Read/write (1 = read, 0 = write) and the data-memory select already carry the request's values at that point.
- R3: The low address byte is on the shared lane only during the first timing state, which is the first two clocks. The high address lane holds the request's upper byte from the address strobe falling until the acknowledge.
- R4: On a write, the lane is driven (enable 1) with the write byte from one clock before the data strobe falls until the data strobe rises.
- R5: On a read, the lane enable is 0 from one clock before the data strobe falls until the data strobe rises.
- R6: On a read, the read data output takes the lane value sampled in the last clock that the data strobe is low, and presents it with the acknowledge. A write leaves the read data output unchanged.
- R7: The acknowledge is high for exactly one clock: the first clock with the data strobe high again after its low window.
- R8: The data strobe is low for 2*STATE_CLKS-1 clocks under normal timing and 3*STATE_CLKS-1 clocks under extended timing (3 and 5 with the default of 2 clocks per timing state). The machine cycle therefore spans 6 or 8 clocks.
- R9: A configuration write sets extended timing when data bit 5 is 1 and normal timing when it is 0. All other data bits are ignored. After reset, extended timing is selected.
- R10: A configuration write made during a transaction leaves that transaction's timing unchanged. It applies from the next accepted request.
- R11: Address, write data, direction and select are captured when the request is accepted. Changes on the request inputs during the transaction do not alter the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transaction request, held until acknowledge |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_dsel_i | input | 1 | Data-memory select for this transaction |
| req_addr_i | input | 16 | Transaction address |
| req_wdata_i | input | 8 | Write byte |
| ack_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Read byte, valid with ack_o |
| cfg_we_i | input | 1 | Configuration register write enable |
| cfg_d_i | input | 8 | Configuration byte (bit 5 = extended timing) |
| bus_ad_o | output | 8 | Shared address/data lane output |
| bus_ad_oe_o | output | 1 | Shared lane drive enable |
| bus_ad_i | input | 8 | Shared lane input |
| bus_ahi_o | output | 8 | High address byte |
| bus_rw_o | output | 1 | 1 = read, 0 = write |
| bus_dsel_o | output | 1 | Data-memory select |
| bus_as_n_o | output | 1 | Address strobe, active low |
| bus_ds_n_o | output | 1 | Data strobe, active low |

## Verification
The bench uses the defaults: a 16-bit address, an 8-bit lane and two clocks per timing state. With these values both strobe windows (3 and 5 clocks) are short enough to check clock by clock. Every transaction is followed from the clock in which its request is accepted up to one clock past its acknowledge. The simulated memory drives a distinct value only while the data strobe is low, so a read sampled in the wrong clock shows up as the idle value. Changing the timing mode in the middle of a transaction, and sending configuration bytes that set every bit except bit 5, exercise the snapshot and field-decode paths.

// File: rtl/mbc_pkg.sv
`timescale 1ns/1ps
package mbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TX   = 3'd3,
    ST_T3   = 3'd4,
    ST_DONE = 3'd5
  } mbc_state_e;

  // Decoded timing controls handed from the sequencer to the datapath.
  typedef struct packed {
    logic as_low;
    logic ds_low;
    logic addr_ph;
    logic data_ph;
    logic capture;
    logic done;
  } mbc_strobe_t;

endpackage

// File: rtl/mbc_rst_sync.sv
`timescale 1ns/1ps
module mbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mbc_mode_reg.sv
`timescale 1ns/1ps
module mbc_mode_reg #(
  parameter int   DATA_W       = 8,
  parameter int   EXT_BIT      = 5,
  parameter logic EXT_AT_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_d,
  output logic              ext_mode
);

  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << EXT_BIT;

  logic ext_q;
  logic ext_d;
  logic cfg_unused;

  // Bits other than the timing select carry no function.
  assign cfg_unused = ^(cfg_d & ~KEEP_MASK);

  always_comb begin
    ext_d = ext_q;
    if (cfg_we) begin
      ext_d = cfg_d[EXT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= EXT_AT_RESET;
    end else begin
      ext_q <= ext_d;
    end
  end

  assign ext_mode = ext_q;

endmodule

// File: rtl/mbc_seq.sv
`timescale 1ns/1ps
module mbc_seq
  import mbc_pkg::*;
#(
  parameter int STATE_CLKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        ext_cfg,
  output logic        start,
  output mbc_strobe_t strb
);

  localparam int PH_W = (STATE_CLKS > 1) ? $clog2(STATE_CLKS) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(STATE_CLKS - 1);

  mbc_state_e      st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            ext_q;
  logic            adv;
  logic            in_cycle;

  assign adv      = (ph_q == LAST_PH);
  assign in_cycle = (st_q == ST_T1) || (st_q == ST_T2) ||
                    (st_q == ST_TX) || (st_q == ST_T3);

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    ph_d  = ph_q;
    start = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req) begin
          st_d  = ST_T1;
          start = 1'b1;
        end
      end
      ST_T1:   if (adv) st_d = ST_T2;
      ST_T2:   if (adv) st_d = ext_q ? ST_TX : ST_T3;
      ST_TX:   if (adv) st_d = ST_T3;
      ST_T3:   if (adv) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (in_cycle) begin
      ph_d = adv ? '0 : ph_q + PH_W'(1);
    end else begin
      ph_d = '0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ph_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  // Timing mode snapshot, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
    end else if (start) begin
      ext_q <= ext_cfg;
    end
  end

  // Strobe decode
  always_comb begin
    strb.as_low  = (st_q == ST_T1) && (ph_q == '0);
    strb.addr_ph = (st_q == ST_T1);
    strb.data_ph = (st_q == ST_T2) || (st_q == ST_TX) || (st_q == ST_T3);
    strb.ds_low  = strb.data_ph && !((st_q == ST_T2) && (ph_q == '0));
    strb.capture = (st_q == ST_T3) && adv;
    strb.done    = (st_q == ST_DONE);
  end

endmodule

// File: rtl/mbc_datapath.sv
`timescale 1ns/1ps
module mbc_datapath
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  mbc_strobe_t              strb,
  input  logic                     req_we,
  input  logic                     req_dsel,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] ahi,
  output logic                     rw,
  output logic                     dsel,
  output logic [DATA_W-1:0]        rdata,
  output logic                     ack
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic              we_q;
  logic              dsel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              txn_en;
  logic              cap_en;

  assign txn_en = start;
  assign cap_en = strb.capture && !we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      dsel_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (txn_en) begin
      we_q    <= req_we;
      dsel_q  <= req_dsel;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= ad_i;
    end
  end

  always_comb begin
    ad_o  = strb.addr_ph ? addr_q[DATA_W-1:0] : wdata_q;
    ad_oe = strb.addr_ph || (strb.data_ph && we_q);
  end

  assign ahi   = addr_q[ADDR_W-1 -: HI_W];
  assign rw    = !we_q;
  assign dsel  = dsel_q;
  assign rdata = rdata_q;
  assign ack   = strb.done;

endmodule

// File: rtl/mux_bus_ctrl.sv
`timescale 1ns/1ps
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int   ADDR_W       = 16,
  parameter int   DATA_W       = 8,
  parameter int   STATE_CLKS   = 2,
  parameter int   EXT_BIT      = 5,
  parameter logic EXT_AT_RESET = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_i,
  input  logic                     req_we_i,
  input  logic                     req_dsel_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  output logic                     ack_o,
  output logic [DATA_W-1:0]        rdata_o,
  input  logic                     cfg_we_i,
  input  logic [DATA_W-1:0]        cfg_d_i,
  output logic [DATA_W-1:0]        bus_ad_o,
  output logic                     bus_ad_oe_o,
  input  logic [DATA_W-1:0]        bus_ad_i,
  output logic [ADDR_W-DATA_W-1:0] bus_ahi_o,
  output logic                     bus_rw_o,
  output logic                     bus_dsel_o,
  output logic                     bus_as_n_o,
  output logic                     bus_ds_n_o
);

  logic        rst_int_n;
  logic        ext_mode;
  logic        start;
  mbc_strobe_t strb;

  mbc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mbc_mode_reg #(
    .DATA_W       (DATA_W),
    .EXT_BIT      (EXT_BIT),
    .EXT_AT_RESET (EXT_AT_RESET)
  ) u_mode_reg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cfg_we   (cfg_we_i),
    .cfg_d    (cfg_d_i),
    .ext_mode (ext_mode)
  );

  mbc_seq #(.STATE_CLKS(STATE_CLKS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req     (req_i),
    .ext_cfg (ext_mode),
    .start   (start),
    .strb    (strb)
  );

  mbc_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_datapath (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .strb      (strb),
    .req_we    (req_we_i),
    .req_dsel  (req_dsel_i),
    .req_addr  (req_addr_i),
    .req_wdata (req_wdata_i),
    .ad_i      (bus_ad_i),
    .ad_o      (bus_ad_o),
    .ad_oe     (bus_ad_oe_o),
    .ahi       (bus_ahi_o),
    .rw        (bus_rw_o),
    .dsel      (bus_dsel_o),
    .rdata     (rdata_o),
    .ack       (ack_o)
  );

  assign bus_as_n_o = !strb.as_low;
  assign bus_ds_n_o = !strb.ds_low;

endmodule

// File: rtl/mbc_chk.sv
`timescale 1ns/1ps
module mbc_chk #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int STATE_CLKS = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ack_o,
  input logic                     bus_ad_oe_o,
  input logic                     bus_rw_o,
  input logic                     bus_as_n_o,
  input logic                     bus_ds_n_o,
  input logic [ADDR_W-DATA_W-1:0] bus_ahi_o
);

  localparam logic [7:0] NRM_LOW = 8'(2 * STATE_CLKS - 1);
  localparam logic [7:0] EXT_LOW = 8'(3 * STATE_CLKS - 1);

  logic [7:0] ds_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_cnt_q <= '0;
    end else if (!bus_ds_n_o) begin
      ds_cnt_q <= ds_cnt_q + 8'd1;
    end else begin
      ds_cnt_q <= '0;
    end
  end

  assert_as_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as_n_o) |=> bus_as_n_o);

  assert_addr_driven_at_as_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_n_o) |-> bus_ad_oe_o);

  assert_ahi_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ds_n_o |-> $stable(bus_ahi_o));

  assert_write_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ds_n_o && !bus_rw_o) |-> bus_ad_oe_o);

  assert_read_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ds_n_o && bus_rw_o) |-> !bus_ad_oe_o);

  assert_ack_after_ds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (bus_ds_n_o && !$past(bus_ds_n_o)));

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  assert_ds_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ds_n_o) |-> (ds_cnt_q == NRM_LOW || ds_cnt_q == EXT_LOW));

  assert_strobes_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_as_n_o && !bus_ds_n_o));

endmodule

bind mux_bus_ctrl mbc_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .STATE_CLKS (STATE_CLKS)
) u_mbc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ack_o       (ack_o),
  .bus_ad_oe_o (bus_ad_oe_o),
  .bus_rw_o    (bus_rw_o),
  .bus_as_n_o  (bus_as_n_o),
  .bus_ds_n_o  (bus_ds_n_o),
  .bus_ahi_o   (bus_ahi_o)
);

// File: tb/mux_bus_ctrl_bench.sv
`timescale 1ns/1ps
module mux_bus_ctrl_bench;

  localparam int SC = 2;

  logic        clk;
  logic        rst_n;
  logic        req_i, req_we_i, req_dsel_i;
  logic [15:0] req_addr_i;
  logic [7:0]  req_wdata_i;
  logic        ack_o;
  logic [7:0]  rdata_o;
  logic        cfg_we_i;
  logic [7:0]  cfg_d_i;
  logic [7:0]  bus_ad_o;
  logic        bus_ad_oe_o;
  logic [7:0]  bus_ad_i;
  logic [7:0]  bus_ahi_o;
  logic        bus_rw_o, bus_dsel_o, bus_as_n_o, bus_ds_n_o;
  logic [7:0]  dev_val;

  int checks;
  int errors;
  int cyc;
  bit finished;

  mux_bus_ctrl u_mux_bus_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_i(req_i), .req_we_i(req_we_i), .req_dsel_i(req_dsel_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .ack_o(ack_o), .rdata_o(rdata_o),
    .cfg_we_i(cfg_we_i), .cfg_d_i(cfg_d_i),
    .bus_ad_o(bus_ad_o), .bus_ad_oe_o(bus_ad_oe_o), .bus_ad_i(bus_ad_i),
    .bus_ahi_o(bus_ahi_o), .bus_rw_o(bus_rw_o), .bus_dsel_o(bus_dsel_o),
    .bus_as_n_o(bus_as_n_o), .bus_ds_n_o(bus_ds_n_o)
  );

  // Memory model: drives its byte only while the data strobe is low.
  assign bus_ad_i = bus_ds_n_o ? 8'hEE : dev_val;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      summary();
      $finish;
    end
  end

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk);
    cfg_we_i = 1'b1;
    cfg_d_i  = v;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // Runs one transaction and checks every clock of it.
  task automatic run_txn(input bit we, input bit dsel, input logic [15:0] addr,
                         input logic [7:0] wd, input logic [7:0] rv, input bit ext,
                         input bit mid_cfg, input logic [7:0] mid_val);
    int L;
    logic [7:0] rd_before;
    L = ext ? 3*SC-1 : 2*SC-1;
    rd_before = rdata_o;
    dev_val = rv;
    @(negedge clk);
    req_i = 1'b1; req_we_i = we; req_dsel_i = dsel;
    req_addr_i = addr; req_wdata_i = wd;
    for (int c = 1; c <= L + 5; c++) begin
      @(negedge clk);
      if (c == 1) begin
        chk(bus_as_n_o == 1'b0, "R2 as low first clock", bus_as_n_o, 0);
        chk(bus_ad_oe_o && bus_ad_o == addr[7:0], "R3 low addr in T1", bus_ad_o, addr[7:0]);
        chk(bus_ahi_o == addr[15:8], "R3 high addr", bus_ahi_o, addr[15:8]);
        // R11: change the request inputs after acceptance
        req_addr_i = ~addr; req_wdata_i = ~wd; req_we_i = ~we; req_dsel_i = ~dsel;
      end else if (c == 2) begin
        chk(bus_as_n_o == 1'b1, "R2 as back high", bus_as_n_o, 1);
        chk(bus_ad_oe_o && bus_ad_o == addr[7:0], "R2 addr at as rise", bus_ad_o, addr[7:0]);
        chk(bus_rw_o == !we, "R2 rw at as rise", bus_rw_o, !we);
        chk(bus_dsel_o == dsel, "R2 dsel at as rise", bus_dsel_o, dsel);
        chk(bus_ds_n_o == 1'b1, "R8 ds high in T1", bus_ds_n_o, 1);
      end else if (c == 3) begin
        chk(bus_ds_n_o == 1'b1, "R8 ds high turnaround", bus_ds_n_o, 1);
        if (we) chk(bus_ad_oe_o && bus_ad_o == wd, "R4 write data before ds", bus_ad_o, wd);
        else    chk(bus_ad_oe_o == 1'b0, "R5 read lane released before ds", bus_ad_oe_o, 0);
      end else if (c <= 3 + L) begin
        chk(bus_ds_n_o == 1'b0, "R8 ds low window", bus_ds_n_o, 0);
        chk(bus_as_n_o == 1'b1 && ack_o == 1'b0, "R7 no ack during ds", ack_o, 0);
        chk(bus_ahi_o == addr[15:8], "R11 high addr held", bus_ahi_o, addr[15:8]);
        chk(bus_rw_o == !we && bus_dsel_o == dsel, "R11 rw/dsel held", bus_rw_o, !we);
        if (we) chk(bus_ad_oe_o && bus_ad_o == wd, "R4 write data under ds", bus_ad_o, wd);
        else    chk(bus_ad_oe_o == 1'b0, "R5 read lane released", bus_ad_oe_o, 0);
      end else if (c == 4 + L) begin
        chk(bus_ds_n_o == 1'b1, "R8 ds ends on time", bus_ds_n_o, 1);
        chk(ack_o == 1'b1, "R7 ack after ds rise", ack_o, 1);
        if (we) chk(rdata_o == rd_before, "R6 write keeps rdata", rdata_o, rd_before);
        else    chk(rdata_o == rv, "R6 read data with ack", rdata_o, rv);
        req_i = 1'b0;
      end else begin
        chk(ack_o == 1'b0, "R7 ack one clock", ack_o, 0);
        chk(bus_as_n_o && bus_ds_n_o && !bus_ad_oe_o, "R1 idle after txn", bus_ad_oe_o, 0);
      end
      if (c == 3 && mid_cfg) begin
        cfg_we_i = 1'b1; cfg_d_i = mid_val;
      end else begin
        cfg_we_i = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(bus_as_n_o && bus_ds_n_o, "R1 strobes high in reset", {bus_as_n_o, bus_ds_n_o}, 3);
    chk(!bus_ad_oe_o && !ack_o, "R1 lane off no ack in reset", {bus_ad_oe_o, ack_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(bus_as_n_o && bus_ds_n_o, "R1 strobes high idle", {bus_as_n_o, bus_ds_n_o}, 3);
    chk(!bus_ad_oe_o && !ack_o, "R1 lane off idle", {bus_ad_oe_o, ack_o}, 0);
    chk(rdata_o == 8'h00 && bus_rw_o == 1'b1, "R1 rdata zero rw read", rdata_o, 0);
  endtask

  task automatic t_default_ext();
    // R9: extended timing is the reset default
    run_txn(1'b1, 1'b0, 16'h12A5, 8'h3C, 8'h00, 1'b1, 1'b0, 8'h00);
    run_txn(1'b0, 1'b1, 16'hFE01, 8'h00, 8'h96, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_normal_mode();
    // R9: bit 5 clear with every other bit set selects normal timing
    cfg_write(8'hDF);
    run_txn(1'b0, 1'b0, 16'h0000, 8'h00, 8'h5A, 1'b0, 1'b0, 8'h00);
    run_txn(1'b1, 1'b1, 16'hFFFF, 8'hC3, 8'h11, 1'b0, 1'b0, 8'h00);
    run_txn(1'b0, 1'b1, 16'h8001, 8'h00, 8'hA7, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_mode_mid_txn();
    // R10: a configuration write in flight applies to the next transaction
    run_txn(1'b0, 1'b0, 16'h4455, 8'h00, 8'h21, 1'b0, 1'b1, 8'h20);
    run_txn(1'b0, 1'b0, 16'h6677, 8'h00, 8'h42, 1'b1, 1'b1, 8'h00);
    run_txn(1'b1, 1'b0, 16'h2B2B, 8'h81, 8'h00, 1'b0, 1'b0, 8'h00);
    // R9: only bit 5 set selects extended timing again
    cfg_write(8'h20);
    run_txn(1'b0, 1'b1, 16'h9ABC, 8'h00, 8'h0F, 1'b1, 1'b0, 8'h00);
  endtask

  initial begin
    checks = 0; errors = 0; cyc = 0; finished = 0;
    rst_n = 1'b0;
    req_i = 1'b0; req_we_i = 1'b0; req_dsel_i = 1'b0;
    req_addr_i = '0; req_wdata_i = '0;
    cfg_we_i = 1'b0; cfg_d_i = '0; dev_val = 8'h00;
    t_reset();
    t_default_ext();
    t_normal_mode();
    t_mode_mid_txn();
    repeat (4) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

endmodule